// File: doc/BRIEF.md
# Stack Push Sequencer

This block executes one stack push in a small non-pipelined datapath. After a start request it stores the selected 8-bit operand, either the A or the B operand, at the memory location named by a 16-bit stack pointer. It then moves the stack pointer down by one. The block drives a plain synchronous write port to memory, made of an address, write data and a write enable. It reports the end of the operation with a one-cycle done pulse.

The stack pointer does not reach the address register over a full-width path. It travels through a lane multiplexer and a lane demultiplexer, each one data word wide. In the first transfer cycle the even-numbered pointer bits move into the address register, and in the second the odd-numbered bits follow. The transfer path is separate from the operand bus. The memory data register therefore captures the selected operand over the bus during the second transfer cycle. The write is then held for two cycles, and the pointer decrements by its own local logic on the edge that ends the write.

Top module: `stk_push_seq`

## Requirements
- R1: While `rst` is high at a clock edge, the next state is: `sp` all ones, `mem_addr` zero, `mem_wdata` zero, `mem_we` low and `done` low.
- R2: `start` is accepted at a clock edge only while the block is idle. `mem_we` rises on the second edge after the accepting edge and stays high for exactly two cycles.
- R3: While `mem_we` is high, `mem_addr` equals the value `sp` had before the push, and it does not change between the two write cycles.
- R4: `mem_wdata` holds the operand value sampled on the edge where `mem_we` rises. A change of `reg_a` or `reg_b` after that edge does not alter the data written.
- R5: `sel_b` is captured at the accepting edge. The value 0 selects `reg_a` and the value 1 selects `reg_b`.
- R6: On the edge where `mem_we` falls, `sp` becomes its previous value minus one, wrapping from zero to all ones. `done` is high for exactly the one cycle that follows.
- R7: A `start` that is high during any cycle of a push, including the done cycle, is ignored. No second write occurs, `sp` changes only once and `mem_addr` keeps its value afterwards.
- R8: A synchronous reset in the middle of a push aborts it. `mem_we` is low after the reset edge and the R1 values apply.
- R9: After the first transfer edge, the even bit positions (0, 2, 4, ...) of `mem_addr` hold the matching `sp` bits. The odd positions still hold the previous address-register contents until the second transfer edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Push request, sampled while idle |
| sel_b | input | 1 | Operand select: 0 for A, 1 for B |
| reg_a | input | DW | Operand A value |
| reg_b | input | DW | Operand B value |
| mem_addr | output | 2*DW | Memory address (address register) |
| mem_wdata | output | DW | Memory write data (data register) |
| mem_we | output | 1 | Memory write enable |
| done | output | 1 | One-cycle completion pulse |
| sp | output | 2*DW | Current stack pointer |

## Verification
A wrong phase in the controller shows up at the ports within one or two cycles. The write enable appears early or late, or lasts one or three cycles. Alternatively the done pulse does not follow the falling edge of the write. A swapped mux or demux lane corrupts `mem_addr` right after the first transfer edge, before any write happens. A bad pointer decrement is visible on `sp` in the done cycle, and again as a wrong address in the next push. The bench walks the pointer through every value of a narrow configuration, including the wrap from zero, so a fault on any address bit cannot go unnoticed.

// File: rtl/stk_push_pkg.sv
package stk_push_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADR_EVEN,
        PH_ADR_ODD,
        PH_WR1,
        PH_WR2,
        PH_DONE
    } phase_e;

    typedef struct packed {
        phase_e ph;
        logic   sel;
    } ctrl_st_t;

endpackage

// File: rtl/push_ctrl.sv
module push_ctrl
    import stk_push_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic sel_in,
    output logic sel_q,
    output logic xfer_en,
    output logic xfer_odd,
    output logic mdr_ld,
    output logic wr_en,
    output logic sp_dec,
    output logic done
);
    ctrl_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        xfer_en  = 1'b0;
        xfer_odd = 1'b0;
        mdr_ld   = 1'b0;
        wr_en    = 1'b0;
        sp_dec   = 1'b0;
        done     = 1'b0;
        case (st_q.ph)
            PH_IDLE: begin
                if (start) begin
                    st_d.ph  = PH_ADR_EVEN;
                    st_d.sel = sel_in;
                end
            end
            PH_ADR_EVEN: begin
                xfer_en = 1'b1;
                st_d.ph = PH_ADR_ODD;
            end
            PH_ADR_ODD: begin
                xfer_en  = 1'b1;
                xfer_odd = 1'b1;
                mdr_ld   = 1'b1;
                st_d.ph  = PH_WR1;
            end
            PH_WR1: begin
                wr_en   = 1'b1;
                st_d.ph = PH_WR2;
            end
            PH_WR2: begin
                wr_en   = 1'b1;
                sp_dec  = 1'b1;
                st_d.ph = PH_DONE;
            end
            PH_DONE: begin
                done    = 1'b1;
                st_d.ph = PH_IDLE;
            end
            default: st_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.ph  <= PH_IDLE;
            st_q.sel <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sel_q = st_q.sel;

endmodule

// File: rtl/sp_reg.sv
module sp_reg #(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          dec,
    input  logic [AW-1:0] base,
    output logic [AW-1:0] sp_q
);
    logic [AW-1:0] sp_d;

    // local decrement from the latched address copy, wraps naturally
    always_comb begin
        sp_d = sp_q;
        if (dec) sp_d = base - {{(AW-1){1'b0}}, 1'b1};
    end

    always_ff @(posedge clk) begin
        if (rst) sp_q <= '1;
        else     sp_q <= sp_d;
    end

endmodule

// File: rtl/lane_mux.sv
module lane_mux #(
    parameter int DW = 8,
    localparam int AW = 2 * DW
) (
    input  logic [AW-1:0] src,
    input  logic          odd,
    output logic [DW-1:0] lane
);
    for (genvar i = 0; i < DW; i++) begin : g_lane
        assign lane[i] = odd ? src[2*i+1] : src[2*i];
    end
endmodule

// File: rtl/lane_demux.sv
module lane_demux #(
    parameter int DW = 8,
    localparam int AW = 2 * DW
) (
    input  logic [DW-1:0] lane,
    input  logic          odd,
    input  logic          en,
    output logic [AW-1:0] wmask,
    output logic [AW-1:0] wval
);
    for (genvar i = 0; i < DW; i++) begin : g_lane
        assign wmask[2*i]   = en & ~odd;
        assign wmask[2*i+1] = en & odd;
        assign wval[2*i]    = lane[i];
        assign wval[2*i+1]  = lane[i];
    end
endmodule

// File: rtl/stk_push_seq.sv
module stk_push_seq #(
    parameter int DW = 8,
    localparam int AW = 2 * DW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          sel_b,
    input  logic [DW-1:0] reg_a,
    input  logic [DW-1:0] reg_b,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic          mem_we,
    output logic          done,
    output logic [AW-1:0] sp
);
    typedef struct packed {
        logic [AW-1:0] mar;
        logic [DW-1:0] mdr;
    } dp_t;

    dp_t dp_d, dp_q;

    logic          sel_q, xfer_en, xfer_odd, mdr_ld, sp_dec;
    logic [DW-1:0] lane, bus;
    logic [AW-1:0] wmask, wval;

    push_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .sel_in  (sel_b),
        .sel_q   (sel_q),
        .xfer_en (xfer_en),
        .xfer_odd(xfer_odd),
        .mdr_ld  (mdr_ld),
        .wr_en   (mem_we),
        .sp_dec  (sp_dec),
        .done    (done)
    );

    sp_reg #(.AW(AW)) u_sp (
        .clk (clk),
        .rst (rst),
        .dec (sp_dec),
        .base(dp_q.mar),
        .sp_q(sp)
    );

    lane_mux #(.DW(DW)) u_mux (
        .src (sp),
        .odd (xfer_odd),
        .lane(lane)
    );

    lane_demux #(.DW(DW)) u_demux (
        .lane (lane),
        .odd  (xfer_odd),
        .en   (xfer_en),
        .wmask(wmask),
        .wval (wval)
    );

    assign bus = sel_q ? reg_b : reg_a;

    always_comb begin
        dp_d     = dp_q;
        dp_d.mar = (dp_q.mar & ~wmask) | (wval & wmask);
        if (mdr_ld) dp_d.mdr = bus;
    end

    always_ff @(posedge clk) begin
        if (rst) dp_q <= '0;
        else     dp_q <= dp_d;
    end

    assign mem_addr  = dp_q.mar;
    assign mem_wdata = dp_q.mdr;

endmodule

// File: rtl/push_seq_chk.sv
module push_seq_chk #(
    parameter int DW = 8,
    localparam int AW = 2 * DW
) (
    input logic          clk,
    input logic          rst,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic [DW-1:0] mem_wdata,
    input logic          done,
    input logic [AW-1:0] sp
);
    assert_we_pair_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_we) |=> mem_we);

    assert_we_len_R2: assert property (@(posedge clk) disable iff (rst)
        (mem_we && $past(mem_we)) |=> !mem_we);

    assert_wr_stable_R3: assert property (@(posedge clk) disable iff (rst)
        (mem_we && $past(mem_we)) |-> ($stable(mem_addr) && $stable(mem_wdata)));

    assert_sp_dec_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(mem_we) |-> (sp == ($past(mem_addr) - {{(AW-1){1'b0}}, 1'b1})));

    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(mem_we) && !mem_we));

    assert_done_single_R6: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_sp_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !$fell(mem_we) |-> $stable(sp));
endmodule

bind stk_push_seq push_seq_chk #(.DW(DW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .mem_wdata(mem_wdata),
    .done     (done),
    .sp       (sp)
);

// File: tb/stk_push_seq_test.sv
module stk_push_seq_test;
    localparam int DW = 4;
    localparam int AW = 2 * DW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic          sel_b = 1'b0;
    logic [DW-1:0] reg_a = '0;
    logic [DW-1:0] reg_b = '0;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic          mem_we;
    logic          done;
    logic [AW-1:0] sp;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    logic [AW-1:0] sp_exp;
    logic [AW-1:0] prev_addr;
    logic [AW-1:0] even_mask;

    always #4 clk = ~clk;

    stk_push_seq #(.DW(DW)) uut (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .sel_b    (sel_b),
        .reg_a    (reg_a),
        .reg_b    (reg_b),
        .mem_addr (mem_addr),
        .mem_wdata(mem_wdata),
        .mem_we   (mem_we),
        .done     (done),
        .sp       (sp)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic finish_up();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    task automatic check_reset_vals(input string req);
        chk(sp == '1, req, 32'(sp), 32'(AW'('1)));
        chk(mem_addr == '0, req, 32'(mem_addr), 0);
        chk(mem_wdata == '0, req, 32'(mem_wdata), 0);
        chk(mem_we == 1'b0, req, 32'(mem_we), 0);
        chk(done == 1'b0, req, 32'(done), 0);
    endtask

    task automatic do_push(input logic selb, input logic [DW-1:0] a,
                           input logic [DW-1:0] b, input bit glitch, input bit restart);
        logic [DW-1:0] wexp;
        logic [AW-1:0] mid;
        wexp = selb ? b : a;
        @(negedge clk);
        start = 1'b1; sel_b = selb; reg_a = a; reg_b = b;
        @(negedge clk);                      // first transfer cycle
        start = restart;
        if (restart) sel_b = ~selb;          // R5: late select must be ignored
        chk(mem_we == 1'b0, "R2 early we", 32'(mem_we), 0);
        chk(sp == sp_exp, "R6 sp hold", 32'(sp), 32'(sp_exp));
        @(negedge clk);                      // second transfer cycle
        mid = (sp_exp & even_mask) | (prev_addr & ~even_mask);
        chk(mem_addr == mid, "R9 even half", 32'(mem_addr), 32'(mid));
        chk(mem_we == 1'b0, "R2 early we", 32'(mem_we), 0);
        @(negedge clk);                      // first write cycle
        chk(mem_we == 1'b1, "R2 we first", 32'(mem_we), 1);
        chk(mem_addr == sp_exp, "R3 addr", 32'(mem_addr), 32'(sp_exp));
        chk(mem_wdata == wexp, "R5 data select", 32'(mem_wdata), 32'(wexp));
        if (glitch) begin reg_a = ~a; reg_b = ~b; end
        @(negedge clk);                      // second write cycle
        chk(mem_we == 1'b1, "R2 we second", 32'(mem_we), 1);
        chk(mem_addr == sp_exp, "R3 addr stable", 32'(mem_addr), 32'(sp_exp));
        chk(mem_wdata == wexp, "R4 data held", 32'(mem_wdata), 32'(wexp));
        @(negedge clk);                      // done cycle
        chk(mem_we == 1'b0, "R2 we length", 32'(mem_we), 0);
        chk(done == 1'b1, "R6 done", 32'(done), 1);
        chk(sp == AW'(sp_exp - 1'b1), "R6 decrement", 32'(sp), 32'(AW'(sp_exp - 1'b1)));
        start = 1'b0;
        @(negedge clk);
        chk(done == 1'b0, "R6 done single", 32'(done), 0);
        chk(mem_we == 1'b0, "R7 no restart", 32'(mem_we), 0);
        @(negedge clk);
        @(negedge clk);
        chk(mem_addr == sp_exp, "R7 addr untouched", 32'(mem_addr), 32'(sp_exp));
        chk(sp == AW'(sp_exp - 1'b1), "R7 sp once", 32'(sp), 32'(AW'(sp_exp - 1'b1)));
        prev_addr = sp_exp;
        sp_exp    = AW'(sp_exp - 1'b1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog act=timeout exp=finish");
        finish_up();
    end

    initial begin
        for (int k = 0; k < AW; k += 2) even_mask[k] = 1'b1;
        for (int k = 1; k < AW; k += 2) even_mask[k] = 1'b0;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check_reset_vals("R1 reset");
        rst = 1'b0;
        sp_exp = '1;
        prev_addr = '0;

        // exhaustive pointer sweep including wrap from zero back to all ones
        for (int i = 0; i <= (1 << AW); i++) begin
            do_push(logic'(i[0] ^ i[4]), DW'(i * 7 + 3), DW'(i * 5 + 1),
                    bit'(i[1]), bit'(i[2] & i[0]));
        end
        chk(sp_exp == AW'('1 - 1), "R6 wrap count", 32'(sp_exp), 32'(AW'('1 - 1)));

        // R8: reset in the middle of the write
        @(negedge clk);
        start = 1'b1; sel_b = 1'b1; reg_b = DW'(5);
        @(negedge clk); start = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk(mem_we == 1'b1, "R8 in write", 32'(mem_we), 1);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check_reset_vals("R8 abort");
        rst = 1'b0;
        sp_exp = '1;
        prev_addr = '0;
        do_push(1'b0, DW'(9), DW'(6), 1'b0, 1'b0);

        finish_up();
    end
endmodule